// File: doc/BRIEF.md
# Selectable Serial Shift Clock Generator

This block makes the bit clock for a synchronous serial port and tells the neighbouring shift register when to move data out and when to capture data in. It has two modes. In internal mode it counts ticks from an upstream prescaler and drives a square wave on the serial clock pad. The period of that wave is a power of two number of ticks, and a 3-bit rate code selects the power. In external mode it releases the pad driver. It passes the pad input through a synchronizer and turns each falling and rising edge of the incoming clock into a one-cycle strobe.

A transfer lasts as long as the `busy` input is high. The shifter outside this block raises `busy` to start a transfer and clears it after the last bit. While `busy` is low the clock pad idles high and the divider is held at zero, so every transfer starts from high with a full first half-period. Configuration writes take effect only while the port is idle.

Top module: `shift_clk_gen`

## Requirements
- R1: After reset, `padOut` is 1, `padOe` is 0, and both strobes are 0. The stored configuration after reset is rate code 0, internal mode, driver disabled.
- R2: In internal mode with `busy` high, `padOut` toggles once every H ticks of `tickEn`, where H = 2^(A-1) and A is the rate exponent. Rate codes 0, 1, 2, 3 and 4 give A = 1, 2, 4, 5 and 6. One full clock period is therefore 2^A ticks.
- R3: Rate codes 5, 6 and 7 behave exactly like code 4 (A = 6).
- R4: Only cycles with `tickEn` high advance the divider. With sparse ticks, the high and low halves each last H ticks, which gives a 50% duty cycle counted in ticks.
- R5: `shiftStb` pulses for one cycle in the same cycle that `padOut` first shows a falling edge. `sampleStb` pulses in the same cycle that `padOut` first shows a rising edge. The result is exactly one shift and one sample per clock period.
- R6: Whenever `busy` is sampled low, `padOut` is 1 in the next cycle, even in the middle of a low half. The divider restarts from zero, so the first half of the next transfer is a full H ticks.
- R7: `cfgWr` loads `cfgRateSel`, `cfgExtSel` and `cfgOutEn` only when `busy` is low in that cycle. A write in any cycle with `busy` high has no effect, and that includes the first cycle of a transfer.
- R8: In external mode (`cfgExtSel` = 1) with `busy` high, `padIn` passes through a two-stage synchronizer. A falling edge on `padIn` before rising clock edge k makes `shiftStb` high for one cycle after edge k+2. A rising edge gives `sampleStb` with the same latency. `padOut` stays 1 in this mode.
- R9: `padOe` equals the stored output-enable bit in internal mode and is 0 in external mode.
- R10: No strobe is produced while `busy` is low, whatever happens on `padIn` or `tickEn`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickEn | input | 1 | Prescaler tick, one-cycle enable |
| cfgWr | input | 1 | Write strobe for the configuration fields |
| cfgRateSel | input | 3 | Rate code (0..4 give exponent 1,2,4,5,6; 5..7 as 4) |
| cfgExtSel | input | 1 | 1 selects external clock mode |
| cfgOutEn | input | 1 | Pad driver enable used in internal mode |
| busy | input | 1 | Transfer active, driven by the shifter |
| padIn | input | 1 | Serial clock pad input |
| padOut | output | 1 | Serial clock pad output value |
| padOe | output | 1 | Serial clock pad output enable |
| shiftStb | output | 1 | One-cycle strobe to shift the next bit out |
| sampleStb | output | 1 | One-cycle strobe to capture the incoming bit |

## Verification
Two events can land on the same clock edge: a configuration write and the start of a transfer. The bench raises `busy` and pulses `cfgWr` with a different rate code, external mode and a different driver enable, all in the same cycle. It then checks, cycle by cycle, that the transfer runs at the old half-period and that `padOe` keeps its old value. A following transfer with no new write confirms that the old rate code is still stored. The same per-cycle comparison, driven by tick counts in the bench, covers all eight rate codes, a sparse tick pattern, a transfer aborted in a low half, and external edges at the fastest allowed spacing.

// File: rtl/sclk_pkg.sv
package sclk_pkg;

  localparam int RATE_W = 3;

  // Control to datapath strobes
  typedef struct packed {
    logic hold;     // port idle: force pad high, clear divider
    logic tickGo;   // internal mode, active, prescaler tick present
    logic extMode;  // external clock path selected
  } sclk_ctl_t;

  // Sparse exponent map; codes above 4 saturate to the slowest rate
  function automatic int unsigned rateExp(input logic [RATE_W-1:0] code);
    case (code)
      3'd0:    return 1;
      3'd1:    return 2;
      3'd2:    return 4;
      3'd3:    return 5;
      default: return 6;
    endcase
  endfunction

endpackage

// File: rtl/sclk_ctrl.sv
module sclk_ctrl
  import sclk_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic              cfgWr,
  input  logic [RATE_W-1:0] cfgRateSel,
  input  logic              cfgExtSel,
  input  logic              cfgOutEn,
  input  logic              busy,
  output sclk_ctl_t         ctl,
  output logic [CNT_W-1:0]  halfLast,
  output logic              padOe
);

  logic [RATE_W-1:0] rateQ;
  logic              extQ;
  logic              oeQ;
  logic [CNT_W:0]    halfCount;
  logic [CNT_W:0]    halfMinus;

  // Configuration accepted only while idle
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rateQ <= '0;
      extQ  <= 1'b0;
      oeQ   <= 1'b0;
    end else if (cfgWr && !busy) begin
      rateQ <= cfgRateSel;
      extQ  <= cfgExtSel;
      oeQ   <= cfgOutEn;
    end
  end

  always_comb begin
    halfCount = (CNT_W+1)'(1) << (rateExp(rateQ) - 1);
    halfMinus = halfCount - (CNT_W+1)'(1);
    halfLast  = halfMinus[CNT_W-1:0];
  end

  always_comb begin
    ctl.hold    = ~busy;
    ctl.tickGo  = busy & tickEn & ~extQ;
    ctl.extMode = extQ;
  end

  assign padOe = oeQ & ~extQ;

endmodule

// File: rtl/sclk_dp.sv
module sclk_dp
  import sclk_pkg::*;
#(
  parameter int CNT_W       = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  sclk_ctl_t        ctl,
  input  logic [CNT_W-1:0] halfLast,
  input  logic             padIn,
  output logic             sckOut,
  output logic             shiftStb,
  output logic             sampleStb
);

  localparam int SYNC_TOP = SYNC_STAGES;

  logic [CNT_W-1:0]  cnt;
  logic              sckQ;
  logic              shiftQ;
  logic              sampleQ;
  logic [SYNC_TOP:0] syncQ;   // [SYNC_TOP-1] synchronized, [SYNC_TOP] previous
  logic              extFall;
  logic              extRise;

  // Synchronizer chain, idles high like the clock line
  always_ff @(posedge clk) begin
    if (!rstN) syncQ <= '1;
    else       syncQ <= {syncQ[SYNC_TOP-1:0], padIn};
  end

  assign extFall = syncQ[SYNC_TOP] & ~syncQ[SYNC_TOP-1];
  assign extRise = ~syncQ[SYNC_TOP] & syncQ[SYNC_TOP-1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt     <= '0;
      sckQ    <= 1'b1;
      shiftQ  <= 1'b0;
      sampleQ <= 1'b0;
    end else begin
      shiftQ  <= 1'b0;
      sampleQ <= 1'b0;
      if (ctl.hold) begin
        cnt  <= '0;
        sckQ <= 1'b1;
      end else if (ctl.extMode) begin
        shiftQ  <= extFall;
        sampleQ <= extRise;
      end else if (ctl.tickGo) begin
        if (cnt == halfLast) begin
          cnt     <= '0;
          sckQ    <= ~sckQ;
          shiftQ  <= sckQ;
          sampleQ <= ~sckQ;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  assign sckOut    = sckQ;
  assign shiftStb  = shiftQ;
  assign sampleStb = sampleQ;

endmodule

// File: rtl/shift_clk_gen.sv
module shift_clk_gen
  import sclk_pkg::*;
#(
  parameter int MAX_EXP     = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tickEn,
  input  logic       cfgWr,
  input  logic [2:0] cfgRateSel,
  input  logic       cfgExtSel,
  input  logic       cfgOutEn,
  input  logic       busy,
  input  logic       padIn,
  output logic       padOut,
  output logic       padOe,
  output logic       shiftStb,
  output logic       sampleStb
);

  localparam int CNT_W = MAX_EXP - 1;

  sclk_ctl_t        ctl;
  logic [CNT_W-1:0] halfLast;

  sclk_ctrl #(.CNT_W(CNT_W)) uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .tickEn    (tickEn),
    .cfgWr     (cfgWr),
    .cfgRateSel(cfgRateSel),
    .cfgExtSel (cfgExtSel),
    .cfgOutEn  (cfgOutEn),
    .busy      (busy),
    .ctl       (ctl),
    .halfLast  (halfLast),
    .padOe     (padOe)
  );

  sclk_dp #(.CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .halfLast (halfLast),
    .padIn    (padIn),
    .sckOut   (padOut),
    .shiftStb (shiftStb),
    .sampleStb(sampleStb)
  );

endmodule

// File: rtl/sclk_chk.sv
module sclk_chk (
  input logic clk,
  input logic rstN,
  input logic busy,
  input logic tickEn,
  input logic padOut,
  input logic padOe,
  input logic shiftStb,
  input logic sampleStb
);

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(shiftStb && sampleStb)); // R5

  AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    !busy |=> padOut); // R6

  AST_TICK_PACED: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy) && (padOut != $past(padOut))) |-> $past(tickEn)); // R4

  AST_OE_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> $stable(padOe)); // R7

  AST_NO_IDLE_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    (shiftStb || sampleStb) |-> $past(busy)); // R10

endmodule

bind shift_clk_gen sclk_chk uChk (
  .clk      (clk),
  .rstN     (rstN),
  .busy     (busy),
  .tickEn   (tickEn),
  .padOut   (padOut),
  .padOe    (padOe),
  .shiftStb (shiftStb),
  .sampleStb(sampleStb)
);

// File: tb/shift_clk_gen_bench.sv
module shift_clk_gen_bench;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tickEn = 1'b0;
  logic       cfgWr = 1'b0;
  logic [2:0] cfgRateSel = 3'd0;
  logic       cfgExtSel = 1'b0;
  logic       cfgOutEn = 1'b0;
  logic       busy = 1'b0;
  logic       padIn = 1'b1;
  logic       padOut, padOe, shiftStb, sampleStb;

  int nRun = 0;
  int nFail = 0;

  always #2 clk = ~clk;

  shift_clk_gen u_shift_clk_gen (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .cfgWr(cfgWr),
    .cfgRateSel(cfgRateSel), .cfgExtSel(cfgExtSel), .cfgOutEn(cfgOutEn),
    .busy(busy), .padIn(padIn), .padOut(padOut), .padOe(padOe),
    .shiftStb(shiftStb), .sampleStb(sampleStb)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int halfOf(input int code);
    int a;
    a = (code == 0) ? 1 : (code == 1) ? 2 : (code == 2) ? 4 : (code == 3) ? 5 : 6;
    return 1 << (a - 1);
  endfunction

  task automatic writeCfg(input int code, input bit ext, input bit oe);
    @(negedge clk);
    cfgRateSel = code[2:0];
    cfgExtSel  = ext;
    cfgOutEn   = oe;
    cfgWr      = 1'b1;
    @(negedge clk);
    cfgWr = 1'b0;
  endtask

  // Internal-mode transfer, checked every cycle; status packed as {pad,shift,sample}
  task automatic runInternal(input int sp, input string tag, input int h,
                             input int nTog, input bit sneak);
    int ticks = 0;
    int toggles = 0;
    bit ep = 1'b1;
    bit es, ess;
    @(negedge clk);
    busy = 1'b1;
    for (int k = 0; toggles < nTog; k++) begin
      tickEn = ((k % sp) == 0);
      cfgWr  = sneak && (k == 0);
      if (sneak && k == 0) begin
        cfgRateSel = 3'd4;
        cfgExtSel  = 1'b1;
        cfgOutEn   = ~padOe;
      end
      @(negedge clk);
      es = 1'b0;
      ess = 1'b0;
      if (tickEn) begin
        ticks++;
        if (ticks % h == 0) begin
          toggles++;
          if (toggles % 2 == 1) begin es = 1'b1; ep = 1'b0; end
          else begin ess = 1'b1; ep = 1'b1; end
        end
      end
      chk(padOut == ep && shiftStb == es && sampleStb == ess, tag,
          {padOut, shiftStb, sampleStb}, {ep, es, ess});
    end
    tickEn = 1'b0;
    cfgWr  = 1'b0;
    busy   = 1'b0;
    @(negedge clk);
    chk(padOut == 1'b1 && !shiftStb && !sampleStb, "R6 idle high",
        {padOut, shiftStb, sampleStb}, 3'b100);
  endtask

  // One external edge, then g-1 more cycles; strobe expected after third edge
  task automatic extEdge(input bit lvl, input int g, input bit act, input string tag);
    @(negedge clk);
    padIn = lvl;
    for (int c = 1; c <= g; c++) begin
      @(negedge clk);
      chk(shiftStb == (act && !lvl && c == 3) && sampleStb == (act && lvl && c == 3)
          && padOut == 1'b1, tag, {padOut, shiftStb, sampleStb},
          {1'b1, act && !lvl && c == 3, act && lvl && c == 3});
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk(padOut == 1'b1 && padOe == 1'b0 && !shiftStb && !sampleStb, "R1 reset",
        {padOut, padOe, shiftStb, sampleStb}, 4'b1000);

    // R2 / R3: sweep every rate code, continuous ticks
    for (int code = 0; code < 8; code++) begin
      writeCfg(code, 1'b0, code[0]);
      @(negedge clk);
      chk(padOe == code[0], "R9 internal oe", int'(padOe), code[0]);
      runInternal(1, (code > 4) ? "R3 saturated code" : "R2 rate code", halfOf(code), 16, 1'b0);
    end

    // R4: sparse ticks, one every 3 cycles
    writeCfg(2, 1'b0, 1'b1);
    runInternal(3, "R4 tick pacing", halfOf(2), 16, 1'b0);
    runInternal(2, "R4 tick pacing", halfOf(2), 16, 1'b0);

    // R7: write in the same cycle the transfer starts is ignored
    writeCfg(0, 1'b0, 1'b1);
    runInternal(1, "R7 write while busy", 1, 16, 1'b1);
    chk(padOe == 1'b1, "R7 oe kept", int'(padOe), 1);
    runInternal(1, "R7 old code kept", 1, 4, 1'b0);

    // R6: abort in a low half, restart with full first half
    writeCfg(1, 1'b0, 1'b1);
    runInternal(1, "R6 abort low", halfOf(1), 3, 1'b0);
    runInternal(1, "R6 full first half", halfOf(1), 16, 1'b0);

    // R8 / R9: external mode
    writeCfg(0, 1'b1, 1'b1);
    @(negedge clk);
    chk(padOe == 1'b0, "R9 external oe", int'(padOe), 0);
    busy = 1'b1;
    for (int b = 0; b < 8; b++) begin
      extEdge(1'b0, 4, 1'b1, "R8 ext fall");
      extEdge(1'b1, 4, 1'b1, "R8 ext rise");
    end
    for (int b = 0; b < 2; b++) begin
      extEdge(1'b0, 7, 1'b1, "R8 ext slow fall");
      extEdge(1'b1, 7, 1'b1, "R8 ext slow rise");
    end
    busy = 1'b0;

    // R10: no strobes while idle
    for (int b = 0; b < 3; b++) begin
      extEdge(1'b0, 4, 1'b0, "R10 idle ext");
      extEdge(1'b1, 4, 1'b0, "R10 idle ext");
    end
    writeCfg(0, 1'b0, 1'b1);
    tickEn = 1'b1;
    for (int c = 0; c < 6; c++) begin
      @(negedge clk);
      chk(!shiftStb && !sampleStb && padOut, "R10 idle ticks",
          {padOut, shiftStb, sampleStb}, 3'b100);
    end
    tickEn = 1'b0;

    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule